// File: doc/BRIEF.md
# Eight-Bit Arithmetic Logic Unit with Status Flags

This block is the arithmetic and logic stage of a small eight-bit datapath. Each cycle it takes an operation code, an accumulator operand, a temporary operand and a carry input. It produces the accumulator result combinationally, in the same cycle. A single binary adder handles every arithmetic operation. Subtraction, compare and decrement reuse that adder by inverting the second operand or the carry, so no separate subtractor exists. A logic unit and a rotate unit supply the remaining operations.

The status byte is a register. It is written on the clock edge that ends a cycle in which `op_valid` is high. Which flag bits an operation may change depends on the operation class. The surrounding datapath reads the result port into its accumulator, and it takes the carry input from its own copy of the carry flag or from any other source it chooses.

Top module: `alu8_core`

## Requirements
- R1: While reset is asserted, and after it is released, the flag byte reads 8'h00.
- R2: The flag byte holds S at bit 7, Z at bit 6, AC at bit 4, P at bit 2 and CY at bit 0. Bits 5, 3 and 1 always read 0.
- R3: When an operation updates S, Z and P, the flag value is taken from a specific byte. For compare (code 9) that byte is the difference. For every other operation it is the result. S is bit 7 of that byte, Z is 1 only when the byte is zero, and P is 1 when the byte has an even number of ones.
- R4: Add (code 0) returns a+b. Add-with-carry (code 1) returns a+b+cin. CY is the carry out of bit 7 and AC is the carry out of bit 3.
- R5: Subtract (code 2) returns a-b and subtract-with-borrow (code 3) returns a-b-cin, both modulo 256. CY is 1 when a borrow occurs. AC is the carry out of bit 3 of the sum a + ~b + (1 - borrow-in).
- R6: Increment (code 4) returns a+1 and decrement (code 5) returns a-1. AC is the carry out of bit 3 of a+1 or of a+8'hFF respectively. CY keeps its previous value.
- R7: AND (code 6), OR (code 7) and XOR (code 8) combine a with b bitwise, and they clear both CY and AC.
- R8: Compare (code 9) returns a unchanged. Its flags are set exactly as subtract (code 2) would set them.
- R9: Rotate-left-around (code 10) moves bit 7 into bit 0, and rotate-right-around (code 11) moves bit 0 into bit 7. The bit that leaves the byte goes to CY, and no other flag changes.
- R10: Rotate-left-through (code 12) moves cin into bit 0 and rotate-right-through (code 13) moves cin into bit 7. CY receives the bit that leaves the byte, and no other flag changes.
- R11: Codes 14 and 15 return a unchanged and leave all flags unchanged.
- R12: The flag byte changes only on a clock edge at which op_valid is 1. When op_valid is 0, every flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Enables the flag register update for this cycle |
| op_sel | input | 4 | Operation code |
| acc_in | input | DATA_W | Accumulator operand a |
| tmp_in | input | DATA_W | Temporary operand b |
| carry_in | input | 1 | Carry or borrow input cin |
| acc_out | output | DATA_W | Result for the accumulator |
| flags | output | 8 | Registered status byte |

## Verification
The result port is combinational, so a wrong operand selection or adder carry shows up on `acc_out` in the same cycle. A fault in the flag logic appears on `flags` one clock edge later. Flags that an operation must preserve are the most likely to hide a fault. A wrongly enabled or cleared CY under increment, decrement or rotate only becomes visible on the next valid operation, so the sweep interleaves operation classes and idle cycles.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_ADC   = 4'd1,
    OP_SUB   = 4'd2,
    OP_SBB   = 4'd3,
    OP_INC   = 4'd4,
    OP_DEC   = 4'd5,
    OP_AND   = 4'd6,
    OP_OR    = 4'd7,
    OP_XOR   = 4'd8,
    OP_CMP   = 4'd9,
    OP_RLC   = 4'd10,
    OP_RRC   = 4'd11,
    OP_RAL   = 4'd12,
    OP_RAR   = 4'd13,
    OP_PASSA = 4'd14,
    OP_PASSB = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    SRC_ADD,
    SRC_LOGIC,
    SRC_SHIFT,
    SRC_PASS
  } res_src_e;

  typedef struct packed {
    logic szp;
    logic ac;
    logic cy;
  } flag_upd_t;

  localparam int unsigned FLAG_W  = 8;
  localparam int unsigned FLG_S   = 7;
  localparam int unsigned FLG_Z   = 6;
  localparam int unsigned FLG_AC  = 4;
  localparam int unsigned FLG_P   = 2;
  localparam int unsigned FLG_CY  = 0;
endpackage

// File: rtl/alu8_rst_sync.sv
module alu8_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              carry_in,
  output logic [DATA_W-1:0] sum,
  output logic              half_carry,
  output logic              full_carry
);
  localparam int LO_W = DATA_W / 2;
  localparam int HI_W = DATA_W - LO_W;

  logic [LO_W:0] lo_sum;
  logic [HI_W:0] hi_sum;

  always_comb begin
    lo_sum = {1'b0, opnd_a[LO_W-1:0]} + {1'b0, opnd_b[LO_W-1:0]}
           + {{LO_W{1'b0}}, carry_in};
    hi_sum = {1'b0, opnd_a[DATA_W-1:LO_W]} + {1'b0, opnd_b[DATA_W-1:LO_W]}
           + {{HI_W{1'b0}}, lo_sum[LO_W]};
    sum        = {hi_sum[HI_W-1:0], lo_sum[LO_W-1:0]};
    half_carry = lo_sum[LO_W];
    full_carry = hi_sum[HI_W];
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] res
);
  always_comb begin
    unique case (op)
      OP_AND:  res = opnd_a & opnd_b;
      OP_OR:   res = opnd_a | opnd_b;
      OP_XOR:  res = opnd_a ^ opnd_b;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] value,
  input  logic              carry_in,
  output logic [DATA_W-1:0] res,
  output logic              carry_out
);
  localparam int MSB = DATA_W - 1;

  always_comb begin
    unique case (op)
      OP_RLC: begin
        res       = {value[MSB-1:0], value[MSB]};
        carry_out = value[MSB];
      end
      OP_RRC: begin
        res       = {value[0], value[MSB:1]};
        carry_out = value[0];
      end
      OP_RAL: begin
        res       = {value[MSB-1:0], carry_in};
        carry_out = value[MSB];
      end
      OP_RAR: begin
        res       = {carry_in, value[MSB:1]};
        carry_out = value[0];
      end
      default: begin
        res       = value;
        carry_out = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              update_en,
  input  flag_upd_t         upd,
  input  logic [DATA_W-1:0] szp_src,
  input  logic              ac_in,
  input  logic              cy_in,
  output logic [FLAG_W-1:0] flags_q
);
  logic [FLAG_W-1:0] flags_d;

  always_comb begin
    flags_d = flags_q;
    if (upd.szp) begin
      flags_d[FLG_S] = szp_src[DATA_W-1];
      flags_d[FLG_Z] = (szp_src == '0);
      flags_d[FLG_P] = ~^szp_src;
    end
    if (upd.ac) flags_d[FLG_AC] = ac_in;
    if (upd.cy) flags_d[FLG_CY] = cy_in;
    flags_d[5] = 1'b0;
    flags_d[3] = 1'b0;
    flags_d[1] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flags_q <= '0;
    else if (update_en) flags_q <= flags_d;
  end

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !update_en |=> $stable(flags_q));

  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flags_q[5] == 1'b0 && flags_q[3] == 1'b0 && flags_q[1] == 1'b0));

  p_cy_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (update_en && !upd.cy) |=> flags_q[FLG_CY] == $past(flags_q[FLG_CY]));
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_sel,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] tmp_in,
  input  logic              carry_in,
  output logic [DATA_W-1:0] acc_out,
  output logic [7:0]        flags
);
  alu_op_e           op;
  res_src_e          src;
  flag_upd_t         upd;
  logic              rst_sync_n;
  logic [DATA_W-1:0] add_b;
  logic              add_cin;
  logic              borrow_mode;
  logic [DATA_W-1:0] add_sum;
  logic              add_hc;
  logic              add_fc;
  logic [DATA_W-1:0] logic_res;
  logic [DATA_W-1:0] shift_res;
  logic              shift_cy;
  logic [DATA_W-1:0] szp_src;
  logic              ac_val;
  logic              cy_val;

  assign op = alu_op_e'(op_sel);

  alu8_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    add_b       = tmp_in;
    add_cin     = 1'b0;
    borrow_mode = 1'b0;
    src         = SRC_PASS;
    upd         = '{szp: 1'b0, ac: 1'b0, cy: 1'b0};
    unique case (op)
      OP_ADD: begin
        src = SRC_ADD;
        upd = '{szp: 1'b1, ac: 1'b1, cy: 1'b1};
      end
      OP_ADC: begin
        add_cin = carry_in;
        src     = SRC_ADD;
        upd     = '{szp: 1'b1, ac: 1'b1, cy: 1'b1};
      end
      OP_SUB, OP_CMP: begin
        add_b       = ~tmp_in;
        add_cin     = 1'b1;
        borrow_mode = 1'b1;
        src         = (op == OP_CMP) ? SRC_PASS : SRC_ADD;
        upd         = '{szp: 1'b1, ac: 1'b1, cy: 1'b1};
      end
      OP_SBB: begin
        add_b       = ~tmp_in;
        add_cin     = ~carry_in;
        borrow_mode = 1'b1;
        src         = SRC_ADD;
        upd         = '{szp: 1'b1, ac: 1'b1, cy: 1'b1};
      end
      OP_INC: begin
        add_b   = '0;
        add_cin = 1'b1;
        src     = SRC_ADD;
        upd     = '{szp: 1'b1, ac: 1'b1, cy: 1'b0};
      end
      OP_DEC: begin
        add_b   = '1;
        src     = SRC_ADD;
        upd     = '{szp: 1'b1, ac: 1'b1, cy: 1'b0};
      end
      OP_AND, OP_OR, OP_XOR: begin
        src = SRC_LOGIC;
        upd = '{szp: 1'b1, ac: 1'b1, cy: 1'b1};
      end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        src = SRC_SHIFT;
        upd = '{szp: 1'b0, ac: 1'b0, cy: 1'b1};
      end
      default: begin
        src = SRC_PASS;
      end
    endcase
  end

  alu8_adder #(.DATA_W(DATA_W)) u_add (
    .opnd_a     (acc_in),
    .opnd_b     (add_b),
    .carry_in   (add_cin),
    .sum        (add_sum),
    .half_carry (add_hc),
    .full_carry (add_fc)
  );

  alu8_logic #(.DATA_W(DATA_W)) u_logic (
    .op     (op),
    .opnd_a (acc_in),
    .opnd_b (tmp_in),
    .res    (logic_res)
  );

  alu8_shifter #(.DATA_W(DATA_W)) u_shift (
    .op        (op),
    .value     (acc_in),
    .carry_in  (carry_in),
    .res       (shift_res),
    .carry_out (shift_cy)
  );

  always_comb begin
    unique case (src)
      SRC_ADD:   acc_out = add_sum;
      SRC_LOGIC: acc_out = logic_res;
      SRC_SHIFT: acc_out = shift_res;
      default:   acc_out = acc_in;
    endcase
    szp_src = (src == SRC_LOGIC) ? logic_res : add_sum;
    ac_val  = (src == SRC_LOGIC) ? 1'b0 : add_hc;
    unique case (src)
      SRC_LOGIC: cy_val = 1'b0;
      SRC_SHIFT: cy_val = shift_cy;
      default:   cy_val = add_fc ^ borrow_mode;
    endcase
  end

  alu8_flags #(.DATA_W(DATA_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .update_en (op_valid),
    .upd       (upd),
    .szp_src   (szp_src),
    .ac_in     (ac_val),
    .cy_in     (cy_val),
    .flags_q   (flags)
  );

  p_cmp_keeps_acc_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_sel == OP_CMP) |-> (acc_out == acc_in));

  p_add_carry_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_sel == OP_ADD) |=>
      flags[FLG_CY] == ($past(acc_in) > ~$past(tmp_in)));

  p_logic_clears_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR)) |=>
      (!flags[FLG_CY] && !flags[FLG_AC]));

  p_zero_tracks_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && (op_sel == OP_AND || op_sel == OP_XOR)) |=>
      flags[FLG_Z] == ($past(acc_out) == '0));

  p_rotate_keeps_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && (op_sel == OP_RLC || op_sel == OP_RRC ||
                  op_sel == OP_RAL || op_sel == OP_RAR)) |=>
      flags[7:1] == $past(flags[7:1]));
endmodule

// File: tb/alu8_core_test.sv
`timescale 1ns/1ps
module alu8_core_test;
  logic       clk;
  logic       rst_n;
  logic       op_valid;
  logic [3:0] op_sel;
  logic [7:0] acc_in;
  logic [7:0] tmp_in;
  logic       carry_in;
  logic [7:0] acc_out;
  logic [7:0] flags;

  int errors;
  int checks;
  bit done;

  alu8_core #(.DATA_W(8)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_sel   (op_sel),
    .acc_in   (acc_in),
    .tmp_in   (tmp_in),
    .carry_in (carry_in),
    .acc_out  (acc_out),
    .flags    (flags)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input int op);
    case (op)
      0, 1:     return "R4,R3";
      2, 3:     return "R5,R3";
      4, 5:     return "R6,R3";
      6, 7, 8:  return "R7,R3";
      9:        return "R8";
      10, 11:   return "R9";
      12, 13:   return "R10";
      default:  return "R11";
    endcase
  endfunction

  function automatic logic [15:0] model(input int op, input int a, input int b,
                                        input int cin, input logic [7:0] old_f);
    logic [7:0] f;
    int r, t, v, ones, c;
    bit do_szp;
    f = old_f; r = a; v = a; do_szp = 0;
    case (op)
      0, 1: begin
        c = (op == 1) ? cin : 0;
        t = a + b + c; r = t % 256; v = r; do_szp = 1;
        f[0] = (t > 255);
        f[4] = ((a % 16) + (b % 16) + c) > 15;
      end
      2, 3, 9: begin
        c = (op == 3) ? cin : 0;
        t = a - b - c; v = (t + 256) % 256; do_szp = 1;
        r = (op == 9) ? a : v;
        f[0] = (t < 0);
        f[4] = ((a % 16) + (15 - (b % 16)) + (1 - c)) > 15;
      end
      4: begin
        r = (a + 1) % 256; v = r; do_szp = 1;
        f[4] = ((a % 16) == 15);
      end
      5: begin
        r = (a + 255) % 256; v = r; do_szp = 1;
        f[4] = ((a % 16) != 0);
      end
      6, 7, 8: begin
        r = (op == 6) ? (a & b) : (op == 7) ? (a | b) : (a ^ b);
        v = r; do_szp = 1; f[0] = 1'b0; f[4] = 1'b0;
      end
      10: begin r = (a * 2) % 256 + a / 128; f[0] = (a / 128) != 0; end
      11: begin r = a / 2 + (a % 2) * 128;  f[0] = (a % 2) != 0; end
      12: begin r = (a * 2) % 256 + cin;    f[0] = (a / 128) != 0; end
      13: begin r = a / 2 + cin * 128;      f[0] = (a % 2) != 0; end
      default: ;
    endcase
    if (do_szp) begin
      ones = 0;
      for (int k = 0; k < 8; k++) ones += (v >> k) & 1;
      f[7] = (v >= 128);
      f[6] = (v == 0);
      f[2] = (ones % 2) == 0;
    end
    f[5] = 1'b0; f[3] = 1'b0; f[1] = 1'b0;
    model = {r[7:0], f};
  endfunction

  localparam logic [7:0] BV [12] = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F, 8'h80,
                                     8'hFE, 8'hFF, 8'h55, 8'hAA, 8'h08, 8'hF0};

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    logic [7:0] mf;
    logic [15:0] m;
    string prev_tag;
    errors = 0; checks = 0; done = 0;
    rst_n = 1'b0; op_valid = 1'b1; op_sel = 4'd0; acc_in = 8'h00;
    tmp_in = 8'h00; carry_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 flags in reset", flags, 8'h00);
    op_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 flags after release", flags, 8'h00);
    mf = 8'h00;
    prev_tag = "R1";
    for (int op = 0; op < 16; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int bi = 0; bi < 12; bi++) begin
          int cin;
          bit vld;
          @(negedge clk);
          check({prev_tag, " flags"}, flags, mf);
          cin = (a ^ bi) & 1;
          vld = ((a + bi) % 7) != 3;
          op_sel = op[3:0]; acc_in = a[7:0]; tmp_in = BV[bi];
          carry_in = cin[0]; op_valid = vld;
          #1;
          m = model(op, a, int'(BV[bi]), cin, mf);
          check({tag_of(op), " result"}, acc_out, m[15:8]);
          if (vld) begin
            mf = m[7:0];
            prev_tag = tag_of(op);
          end else begin
            prev_tag = "R12";
          end
        end
      end
    end
    @(negedge clk);
    check({prev_tag, " flags"}, flags, mf);
    check("R2 unused bits", flags & 8'h2A, 8'h00);
    op_valid = 1'b0; op_sel = 4'd0; acc_in = 8'hFF; tmp_in = 8'h01;
    @(negedge clk);
    check("R12 idle hold", flags, mf);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired at %0t", $time);
      summary();
      $finish;
    end
  end
endmodule